// File: doc/BRIEF.md
# Word Program Sequencer with Suspend and Resume

This block is the internal engine that carries out a single word program after the command decoder has handed it an address and a data word. It first checks two entry conditions: that the programming supply is valid and that the target block is unlocked. If both hold, it runs a loop of timed pulse and verify phases. Every pulse writes the old array word ANDed with the new data, so a program can only clear bits. If verify keeps failing, the engine retries up to a parameterised number of pulses and then reports a failure.

While the engine runs, it updates a status byte. Bit 7 shows ready or busy. Bit 4 reports a verify failure, bit 3 a supply error, bit 2 a suspension and bit 1 a lock violation. The command bus carries only a few codes the engine acts on: B0h requests a suspend, D0h resumes, and 50h clears the error bits. A suspend is honoured only at the end of a phase. Its latency is therefore bounded by one pulse phase. A resume continues from the saved phase with the latched address and data.

Top module: `prog_seq`

## Requirements
- R1: Status bit 7 reads 0 from the cycle after an accepted start until the operation completes, fails or is suspended, and reads 1 otherwise. The array write strobe is only ever active while bit 7 is 0.
- R2: Each pulse writes (old word AND data) to the latched address. Programming a 1 over a stored 0 leaves that bit at 0 and sets no error bit.
- R3: While the verify-failure input is high at the end of a verify phase, the engine issues another pulse. After MAX_PULSES pulses it stops, sets status bit 4 and returns status bit 7 to 1.
- R4: A start with the supply-valid input low sets status bit 3, performs no array write and leaves bit 7 at 1.
- R5: A start with the supply valid and the block-lock input high sets status bit 1 and performs no write. When the supply is also invalid, only bit 3 is set.
- R6: Status bits 4, 3 and 1 stay set until command 50h arrives while the engine is idle. A 50h issued while a program runs has no effect.
- R7: While a program runs, start requests and command codes other than B0h and D0h are ignored.
- R8: Command B0h during a program suspends it only at the end of the current pulse phase, or at the end of a failing verify phase. Status bits 7 and 2 then both read 1. The delay from the command to bit 2 rising is at most PULSE_CYC cycles.
- R9: Command D0h while suspended clears bits 2 and 7 in the next cycle, and the program completes with the same address and data. D0h and B0h while idle have no effect.
- R10: The idle status word with no errors reads 80h. Bits 6, 5 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a word program with addr_i and data_i |
| addr_i | input | AW | Target word address |
| data_i | input | DW | Data to program |
| vpp_ok_i | input | 1 | Programming supply within limits |
| blk_lock_i | input | 1 | Target block is locked |
| cmd_valid_i | input | 1 | Command code present this cycle |
| cmd_code_i | input | 8 | Command code |
| vfy_fail_i | input | 1 | Forces the verify phase to fail |
| arr_rdata_i | input | DW | Current array word at arr_addr_o |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | AW | Array address |
| arr_wdata_o | output | DW | Array write data |
| status_o | output | 8 | Status byte |

## Verification
A wrong phase counter or a wrong pulse count shows at the array port as a missing or extra write. It also shows in status bit 7, which rises early or late; the error appears within one pulse phase of the fault. A lost suspend request leaves bit 2 low past the PULSE_CYC bound. A lost saved phase shows as an extra or missing write right after the resume. Corrupted sticky error bits show in the status byte read back on the next idle cycle.

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int AW         = 21,
  parameter int DW         = 16,
  parameter int PULSE_CYC  = 16,
  parameter int VFY_CYC    = 8,
  parameter int MAX_PULSES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          vpp_ok_i,
  input  logic          blk_lock_i,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_code_i,
  input  logic          vfy_fail_i,
  input  logic [DW-1:0] arr_rdata_i,
  output logic          arr_we_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [DW-1:0] arr_wdata_o,
  output logic [7:0]    status_o
);

  localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [7:0] C_SUSP = 8'hB0;
  localparam logic [7:0] C_RES  = 8'hD0;
  localparam logic [7:0] C_CLR  = 8'h50;

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_VFY, S_SUSP} st_t;

  st_t           st;
  logic          resume_vfy;
  logic [CW-1:0] cyc;
  logic [PW-1:0] pulses;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          susp_pend;
  logic          err_fail, err_vpp, err_lock;

  wire running   = (st == S_PULSE) || (st == S_VFY);
  wire cmd_susp  = cmd_valid_i && (cmd_code_i == C_SUSP);
  wire cmd_res   = cmd_valid_i && (cmd_code_i == C_RES);
  wire cmd_clr   = cmd_valid_i && (cmd_code_i == C_CLR);
  wire pulse_end = (st == S_PULSE) && (cyc == CW'(PULSE_CYC - 1));
  wire vfy_end   = (st == S_VFY) && (cyc == CW'(VFY_CYC - 1));
  wire want_susp = susp_pend || cmd_susp;
  wire out_of_tries = pulses >= PW'(MAX_PULSES);

  assign arr_we_o    = pulse_end;
  assign arr_addr_o  = addr_q;
  assign arr_wdata_o = arr_rdata_i & data_q;
  assign status_o    = {~running, 2'b00, err_fail, err_vpp, st == S_SUSP, err_lock, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      resume_vfy <= 1'b0;
      cyc        <= '0;
      pulses     <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      susp_pend  <= 1'b0;
      err_fail   <= 1'b0;
      err_vpp    <= 1'b0;
      err_lock   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_i) begin
            if (!vpp_ok_i) err_vpp <= 1'b1;
            else if (blk_lock_i) err_lock <= 1'b1;
            else begin
              addr_q    <= addr_i;
              data_q    <= data_i;
              cyc       <= '0;
              pulses    <= '0;
              susp_pend <= 1'b0;
              st        <= S_PULSE;
            end
          end else if (cmd_clr) begin
            err_fail <= 1'b0;
            err_vpp  <= 1'b0;
            err_lock <= 1'b0;
          end
        end
        S_PULSE: begin
          if (cmd_susp) susp_pend <= 1'b1;
          if (pulse_end) begin
            pulses <= pulses + PW'(1);
            cyc    <= '0;
            if (want_susp) begin
              st         <= S_SUSP;
              resume_vfy <= 1'b1;
              susp_pend  <= 1'b0;
            end else begin
              st <= S_VFY;
            end
          end else begin
            cyc <= cyc + CW'(1);
          end
        end
        S_VFY: begin
          if (cmd_susp) susp_pend <= 1'b1;
          if (vfy_end) begin
            cyc <= '0;
            if (!vfy_fail_i) begin
              st        <= S_IDLE;
              susp_pend <= 1'b0;
            end else if (out_of_tries) begin
              err_fail  <= 1'b1;
              st        <= S_IDLE;
              susp_pend <= 1'b0;
            end else if (want_susp) begin
              st         <= S_SUSP;
              resume_vfy <= 1'b0;
              susp_pend  <= 1'b0;
            end else begin
              st <= S_PULSE;
            end
          end else begin
            cyc <= cyc + CW'(1);
          end
        end
        default: begin
          if (cmd_res) begin
            st  <= resume_vfy ? S_VFY : S_PULSE;
            cyc <= '0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int PULSE_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       vpp_ok_i,
  input logic       blk_lock_i,
  input logic       cmd_valid_i,
  input logic [7:0] cmd_code_i,
  input logic       arr_we_o,
  input logic       rdy,
  input logic       sr_fail,
  input logic       sr_vpp,
  input logic       sr_susp,
  input logic       sr_lock
);

  localparam int LW = $clog2(PULSE_CYC + 2) + 1;

  wire idle = rdy && !sr_susp;
  wire c_susp = cmd_valid_i && (cmd_code_i == 8'hB0);
  wire c_res  = cmd_valid_i && (cmd_code_i == 8'hD0);
  wire c_clr  = cmd_valid_i && (cmd_code_i == 8'h50);

  logic          waiting;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      lat     <= '0;
    end else if (rdy) begin
      waiting <= 1'b0;
      lat     <= '0;
    end else if (waiting) begin
      lat <= lat + LW'(1);
    end else if (c_susp) begin
      waiting <= 1'b1;
      lat     <= LW'(1);
    end
  end

  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    idle && start_i && vpp_ok_i && !blk_lock_i |=> !rdy);
  a_r1_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> !rdy);
  a_r4_supply_abort: assert property (@(posedge clk) disable iff (!rst_n)
    idle && start_i && !vpp_ok_i |=> sr_vpp && rdy);
  a_r5_lock_abort: assert property (@(posedge clk) disable iff (!rst_n)
    idle && start_i && vpp_ok_i && blk_lock_i |=> sr_lock && rdy);
  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sr_fail && !(c_clr && idle) |=> sr_fail);
  a_r8_susp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sr_susp |-> rdy);
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> lat <= LW'(PULSE_CYC));
  a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
    sr_susp && c_res |=> !rdy && !sr_susp);

endmodule

bind prog_seq prog_seq_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .vpp_ok_i(vpp_ok_i),
  .blk_lock_i(blk_lock_i), .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i),
  .arr_we_o(arr_we_o), .rdy(status_o[7]), .sr_fail(status_o[4]),
  .sr_vpp(status_o[3]), .sr_susp(status_o[2]), .sr_lock(status_o[1])
);

// File: tb/prog_seq_tb_top.sv
module prog_seq_tb_top;
  localparam int AW = 6, DW = 16, PC = 8, VC = 4, MP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, vpp_ok_i = 1, blk_lock_i = 0, cmd_valid_i = 0, vfy_fail_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [7:0] cmd_code_i = '0;
  logic [DW-1:0] arr_rdata_i, arr_wdata_o;
  logic [AW-1:0] arr_addr_o;
  logic arr_we_o;
  logic [7:0] status_o;

  logic [DW-1:0] mem [64];
  logic [DW-1:0] ref_mem [64];
  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  prog_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PC), .VFY_CYC(VC), .MAX_PULSES(MP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
    .vpp_ok_i(vpp_ok_i), .blk_lock_i(blk_lock_i), .cmd_valid_i(cmd_valid_i),
    .cmd_code_i(cmd_code_i), .vfy_fail_i(vfy_fail_i), .arr_rdata_i(arr_rdata_i),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o),
    .status_o(status_o));

  assign arr_rdata_i = mem[arr_addr_o];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (rst_n && arr_we_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R4 R5 R7 unexpected write", {10'd0, arr_addr_o, arr_wdata_o}, 32'd0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(it.a == arr_addr_o && it.d == arr_wdata_o, "R2 write item",
              {10'd0, arr_addr_o, arr_wdata_o}, {10'd0, it.a, it.d});
      end
      mem[arr_addr_o] <= arr_wdata_o;
    end
  end

  task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n);
    ref_mem[a] = ref_mem[a] & d;
    for (int i = 0; i < n; i++) exp_q.push_back({a, ref_mem[a]});
    addr_i = a; data_i = d; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic raw_start(input logic [AW-1:0] a);
    addr_i = a; data_i = 16'h0000; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic cmd(input logic [7:0] c);
    cmd_code_i = c; cmd_valid_i = 1;
    @(negedge clk);
    cmd_valid_i = 0;
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!status_o[7] && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(status_o[7], req, {24'd0, status_o}, 32'h80);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'hFFFF ^ DW'(i);
      ref_mem[i] = 16'hFFFF ^ DW'(i);
    end
    mem[5] = 16'h00FF; ref_mem[5] = 16'h00FF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(status_o == 8'h80, "R10 reset status", {24'd0, status_o}, 32'h80);

    prog(3, 16'h1234, 1);
    check(status_o[7] == 0, "R1 busy after start", {24'd0, status_o}, 32'h00);
    wait_ready("R1 ready after program");
    check(status_o == 8'h80, "R1 R10 clean finish", {24'd0, status_o}, 32'h80);
    check(mem[3] == ((16'hFFFF ^ 16'd3) & 16'h1234), "R2 array word", {16'd0, mem[3]}, {16'd0, (16'hFFFF ^ 16'd3) & 16'h1234});

    prog(5, 16'h0F0F, 1);
    wait_ready("R2 ready");
    check(mem[5] == 16'h000F, "R2 one over zero", {16'd0, mem[5]}, 32'h000F);
    check(status_o == 8'h80, "R2 no error", {24'd0, status_o}, 32'h80);

    vpp_ok_i = 0;
    raw_start(10);
    check(status_o == 8'h88, "R4 supply error", {24'd0, status_o}, 32'h88);
    cmd(8'h50);
    check(status_o == 8'h80, "R6 clear idle", {24'd0, status_o}, 32'h80);
    blk_lock_i = 1;
    raw_start(10);
    check(status_o == 8'h88, "R5 supply before lock", {24'd0, status_o}, 32'h88);
    cmd(8'h50);
    vpp_ok_i = 1;
    raw_start(10);
    check(status_o == 8'h82, "R5 lock error", {24'd0, status_o}, 32'h82);
    cmd(8'h50);
    blk_lock_i = 0;

    vfy_fail_i = 1;
    prog(7, 16'h5555, MP);
    wait_ready("R3 ready after fail");
    check(status_o == 8'h90, "R3 verify failure", {24'd0, status_o}, 32'h90);
    check(exp_q.size() == 0, "R3 pulse count", exp_q.size(), 0);
    vfy_fail_i = 0;

    prog(8, 16'hAAAA, 1);
    cmd(8'h50);
    cmd(8'h40);
    raw_start(20);
    check(status_o[7] == 0, "R7 still busy", {24'd0, status_o}, 32'h10);
    wait_ready("R7 ready");
    check(status_o == 8'h90, "R6 R7 clear ignored while busy", {24'd0, status_o}, 32'h90);
    cmd(8'h50);
    check(status_o == 8'h80, "R6 clear", {24'd0, status_o}, 32'h80);

    prog(9, 16'h0FF0, 1);
    repeat (2) @(negedge clk);
    cmd(8'hB0);
    n = 1;
    while (!status_o[2] && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(n <= PC, "R8 suspend latency", n, PC);
    check(status_o == 8'h84, "R8 suspended status", {24'd0, status_o}, 32'h84);
    repeat (20) @(negedge clk);
    cmd(8'hB0);
    check(status_o == 8'h84, "R8 held suspended", {24'd0, status_o}, 32'h84);
    cmd(8'hD0);
    check(status_o == 8'h00, "R9 resume", {24'd0, status_o}, 32'h00);
    wait_ready("R9 completes");
    check(mem[9] == ((16'hFFFF ^ 16'd9) & 16'h0FF0), "R9 data kept", {16'd0, mem[9]}, {16'd0, (16'hFFFF ^ 16'd9) & 16'h0FF0});

    vfy_fail_i = 1;
    prog(11, 16'h3C3C, MP);
    repeat (PC) @(negedge clk);
    cmd(8'hB0);
    repeat (VC) @(negedge clk);
    check(status_o == 8'h84, "R8 suspend at verify end", {24'd0, status_o}, 32'h84);
    check(exp_q.size() == MP - 1, "R8 no write while suspended", exp_q.size(), MP - 1);
    cmd(8'hD0);
    wait_ready("R9 resume into pulse");
    check(status_o == 8'h90, "R3 R9 fail after resume", {24'd0, status_o}, 32'h90);
    vfy_fail_i = 0;
    cmd(8'h50);

    prog(12, 16'hF00F, 1);
    repeat (PC + 1) @(negedge clk);
    cmd(8'hB0);
    wait_ready("R8 pass ends run");
    check(status_o == 8'h80, "R8 no suspend on passing verify", {24'd0, status_o}, 32'h80);

    cmd(8'hB0);
    check(status_o == 8'h80, "R9 idle suspend ignored", {24'd0, status_o}, 32'h80);
    cmd(8'hD0);
    check(status_o == 8'h80, "R9 idle resume ignored", {24'd0, status_o}, 32'h80);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule